// File: doc/BRIEF.md
# Increment-and-Skip Execution Unit

This unit executes two byte-oriented instructions of an 8-bit accumulator-style processor. Both read one byte of data memory and add one to it, with wrap at 256. The result goes either to the working register (W) or back to the same memory location. Each instruction then decides whether to discard the instruction that the fetch stage has already prefetched. The zero-test variant discards it when the new byte is zero. The nonzero-test variant discards it when the new byte is not zero. Neither instruction changes any status flag.

Instruction words arrive on a valid/ready stream. The unit accepts a word only while idle, and it holds `ins_ready` low for the whole execution, so the fetch side has to keep a pending word until ready returns. One instruction cycle lasts `PHASES` clocks (four by default). Phase 0 decodes the word and forms the address. Phase 1 reads memory. Phase 2 computes the new value. Phase 3 writes the destination. A skip adds one NOP instruction cycle for each discarded word and raises `squash` once at the start of each one. The fetch side reports on `next_dbl` whether the prefetched instruction takes two words.

The operand address comes from one of three sources:
- the 4-bit bank register joined with the 8-bit file address;
- a fixed access window;
- the index base `fsr2` plus the file address.

W and the bank register can be loaded through plain ports while the unit is idle.

Top module: `incskip_unit`

## Requirements
- R1: A word whose top six bits are 001111 (skip on zero) or 010010 (skip on nonzero) is executed. In both, bit 9 is the destination bit d, bit 8 is the bank bit a, and bits 7:0 are the file address f. Any other word is accepted, does no read and no write, leaves W unchanged, and holds `ins_ready` low for exactly one clock.
- R2: When a=1 the operand address is {bank register, f}.
- R3: When a=0 and indexed mode does not apply, f below 0x60 gives address 0x000+f and f of 0x60 or above gives 0xF00+f.
- R4: When a=0, `ext_en`=1 and f is at most 0x5F, the address is (`fsr2` + f) mod 4096.
- R5: The result is (byte + 1) mod 256. With d=1 it is written back to the operand address and W is unchanged. With d=0 it is loaded into W and no memory write occurs.
- R6: The skip-on-zero variant skips when the result is 0x00. The skip-on-nonzero variant skips when it is not 0x00.
- R7: Counting the first clock after acceptance as phase 0, `mem_rd` is high in phase 1 only. A data-memory write (`mem_we`) happens in phase 3 only, at the address read in phase 1, and never in the same clock as a read.
- R8: A skip adds one NOP instruction cycle per discarded word: one cycle when `next_dbl`=0 and two when `next_dbl`=1. `squash` is a one-clock pulse in the first clock of each NOP cycle. `ins_ready` stays low for 4, 8 or 12 clocks in total.
- R9: `ins_ready` is high only when idle. A word is taken only on a clock where `ins_valid` and `ins_ready` are both high. A word held on `ins_valid` while the unit is busy is not taken.
- R10: Reset clears W and the bank register. `w_ld`/`bsr_ld` take effect only while `ins_ready` is high and are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction word valid |
| ins_ready | output | 1 | Unit idle, word can be taken |
| ins_word | input | 16 | Instruction word |
| next_dbl | input | 1 | Prefetched instruction occupies two words |
| ext_en | input | 1 | Extended (indexed) addressing enabled |
| fsr2 | input | AW | Index base for indexed mode |
| w_ld | input | 1 | Load W (idle only) |
| w_ld_val | input | DW | Value for W load |
| bsr_ld | input | 1 | Load bank register (idle only) |
| bsr_ld_val | input | AW-DW | Value for bank load |
| w_q | output | DW | Working register |
| bsr_q | output | AW-DW | Bank register |
| mem_addr | output | AW | Data memory address |
| mem_rd | output | 1 | Read strobe; data returns next clock |
| mem_rdata | input | DW | Read data |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |
| squash | output | 1 | Discard one prefetched word |

## Verification
The checker watches the following on every clock:
- reads and writes never coincide;
- each write lands two clocks after a read at the same address and carries that read's data plus one;
- an accepted word drops `ins_ready`;
- `squash` is a lone pulse that only appears while busy;
- the bank register cannot change while busy.

Only the bench scenarios can show the rest:
- which of the three address sources is chosen;
- the skip decision for each variant, including the 0xFF wrap;
- the NOP count that follows from `next_dbl`;
- W versus memory as destination;
- that undefined words and busy-time loads leave no trace.

// File: rtl/incskip_pkg.sv
package incskip_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_NOP} seq_st_e;

  // Top six bits of the two executed opcodes.
  localparam logic [5:0] OP_SKIP_Z  = 6'b001111;
  localparam logic [5:0] OP_SKIP_NZ = 6'b010010;

  typedef struct packed {
    logic       known;    // one of the two opcodes
    logic       test_nz;  // skip when result is nonzero
    logic       to_file;  // d bit: write back to memory
    logic       banked;   // a bit
    logic [7:0] fadr;     // file address
  } ins_dec_t;

endpackage

// File: rtl/incskip_decode.sv
module incskip_decode
  import incskip_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 8,
  parameter int IDX_LIMIT = 8'h5F
) (
  input  logic [15:0]      ins,
  input  logic [AW-DW-1:0] bank,
  input  logic [AW-1:0]    idx_base,
  input  logic             ext_en,
  output ins_dec_t         dec,
  output logic [AW-1:0]    addr
);
  localparam int BW    = AW - DW;
  localparam int SPLIT = IDX_LIMIT + 1;

  logic [5:0] opc;
  logic       use_idx;

  always_comb begin
    opc         = ins[15:10];
    dec.known   = (opc == OP_SKIP_Z) || (opc == OP_SKIP_NZ);
    dec.test_nz = (opc == OP_SKIP_NZ);
    dec.to_file = ins[9];
    dec.banked  = ins[8];
    dec.fadr    = ins[7:0];
  end

  assign use_idx = ext_en && !dec.banked && (int'(dec.fadr) <= IDX_LIMIT);

  always_comb begin
    if (dec.banked)
      addr = {bank, dec.fadr};
    else if (use_idx)
      addr = idx_base + AW'(dec.fadr);
    else if (int'(dec.fadr) < SPLIT)
      addr = {{BW{1'b0}}, dec.fadr};
    else
      addr = {{BW{1'b1}}, dec.fadr};
  end

endmodule

// File: rtl/incskip_alu.sv
module incskip_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] operand,
  input  logic          test_nz,
  output logic [DW-1:0] sum,
  output logic          skip
);
  logic is_zero;

  assign sum     = operand + DW'(1);
  assign is_zero = (sum == '0);
  assign skip    = test_nz ? !is_zero : is_zero;

endmodule

// File: rtl/incskip_seq.sv
module incskip_seq
  import incskip_pkg::*;
#(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic known,
  input  logic skip,
  input  logic dbl,
  output logic idle,
  output logic ph_dec,
  output logic ph_read,
  output logic ph_proc,
  output logic ph_write,
  output logic nop_head
);
  localparam int PW   = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam int LAST = PHASES - 1;

  seq_st_e       st;
  logic [PW-1:0] ph;
  logic [1:0]    nops_left;
  logic          ph_last;

  assign ph_last  = (ph == PW'(LAST));
  assign idle     = (st == ST_IDLE);
  assign ph_dec   = (st == ST_EXEC) && (ph == PW'(0));
  assign ph_read  = (st == ST_EXEC) && (ph == PW'(1));
  assign ph_proc  = (st == ST_EXEC) && (ph == PW'(2));
  assign ph_write = (st == ST_EXEC) && (ph == PW'(3));
  assign nop_head = (st == ST_NOP)  && (ph == PW'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= '0;
      nops_left <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st <= ST_EXEC;
            ph <= '0;
          end
        end
        ST_EXEC: begin
          if (ph_dec && !known) begin
            st <= ST_IDLE;
          end else if (ph_last) begin
            ph <= '0;
            if (skip) begin
              st        <= ST_NOP;
              nops_left <= dbl ? 2'd2 : 2'd1;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            ph <= ph + PW'(1);
          end
        end
        ST_NOP: begin
          if (ph_last) begin
            ph <= '0;
            if (nops_left == 2'd1) st <= ST_IDLE;
            nops_left <= nops_left - 2'd1;
          end else begin
            ph <= ph + PW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/incskip_unit.sv
module incskip_unit
  import incskip_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 8,
  parameter int PHASES    = 4,
  parameter int IDX_LIMIT = 8'h5F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [15:0]      ins_word,
  input  logic             next_dbl,
  input  logic             ext_en,
  input  logic [AW-1:0]    fsr2,
  input  logic             w_ld,
  input  logic [DW-1:0]    w_ld_val,
  input  logic             bsr_ld,
  input  logic [AW-DW-1:0] bsr_ld_val,
  output logic [DW-1:0]    w_q,
  output logic [AW-DW-1:0] bsr_q,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_rd,
  input  logic [DW-1:0]    mem_rdata,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wdata,
  output logic             squash
);
  localparam int BW = AW - DW;

  logic [15:0]   ins_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] res_q;
  logic          skip_q;
  ins_dec_t      dec;
  logic [AW-1:0] addr_c;
  logic [DW-1:0] sum_c;
  logic          skip_c;
  logic          idle, ph_dec, ph_read, ph_proc, ph_write, nop_head;
  logic          accept;

  assign ins_ready = idle;
  assign accept    = ins_valid && idle;

  incskip_decode #(.AW(AW), .DW(DW), .IDX_LIMIT(IDX_LIMIT)) u_dec (
    .ins(ins_q), .bank(bsr_q), .idx_base(fsr2), .ext_en(ext_en),
    .dec(dec), .addr(addr_c)
  );

  incskip_alu #(.DW(DW)) u_alu (
    .operand(mem_rdata), .test_nz(dec.test_nz), .sum(sum_c), .skip(skip_c)
  );

  incskip_seq #(.PHASES(PHASES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .known(dec.known),
    .skip(skip_q), .dbl(next_dbl), .idle(idle), .ph_dec(ph_dec),
    .ph_read(ph_read), .ph_proc(ph_proc), .ph_write(ph_write),
    .nop_head(nop_head)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q  <= '0;
      addr_q <= '0;
      res_q  <= '0;
      skip_q <= 1'b0;
    end else begin
      if (accept)  ins_q  <= ins_word;
      if (ph_dec)  addr_q <= addr_c;
      if (ph_proc) begin
        res_q  <= sum_c;
        skip_q <= skip_c;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q   <= '0;
      bsr_q <= '0;
    end else begin
      if (idle && w_ld)
        w_q <= w_ld_val;
      else if (ph_write && dec.known && !dec.to_file)
        w_q <= res_q;
      if (idle && bsr_ld)
        bsr_q <= bsr_ld_val;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_rd    = ph_read;
  assign mem_we    = ph_write && dec.known && dec.to_file;
  assign mem_wdata = res_q;
  assign squash    = nop_head;

  initial begin
    if (PHASES < 4) $error("PHASES must be at least 4");
    if (BW < 1)     $error("AW must exceed DW");
  end

endmodule

// File: rtl/incskip_chk.sv
module incskip_chk #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic             ins_ready,
  input logic             mem_rd,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_rdata,
  input logic [DW-1:0]    mem_wdata,
  input logic             squash,
  input logic [AW-DW-1:0] bsr_q
);
  // R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  // R7
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2)));

  // R5
  wr_data_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == DW'($past(mem_rdata) + DW'(1))));

  // R9
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |=> !ins_ready);

  // R8
  squash_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> !ins_ready);

  // R8
  squash_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !squash);

  // R10
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_ready |=> $stable(bsr_q));

endmodule

bind incskip_unit incskip_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .squash(squash),
  .bsr_q(bsr_q)
);

// File: tb/incskip_unit_bench.sv
module incskip_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 8;

  typedef struct packed {
    logic [15:0] ins;
    logic [3:0]  bank;
    logic        ext;
    logic [11:0] base;
    logic        dbl;
    logic [7:0]  pre;
    logic [11:0] eaddr;
    logic [7:0]  eval;
    logic        emem;
    logic [1:0]  esq;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{16'h3F20, 4'h3, 1'b0, 12'h000, 1'b0, 8'h05, 12'h320, 8'h06, 1'b1, 2'd0},
    '{16'h3E10, 4'h0, 1'b0, 12'h000, 1'b0, 8'hFF, 12'h010, 8'h00, 1'b1, 2'd1},
    '{16'h3E70, 4'h0, 1'b0, 12'h000, 1'b1, 8'hFF, 12'hF70, 8'h00, 1'b1, 2'd2},
    '{16'h3D05, 4'hA, 1'b0, 12'h000, 1'b0, 8'h7F, 12'hA05, 8'h80, 1'b0, 2'd0},
    '{16'h4A5F, 4'h0, 1'b1, 12'h100, 1'b0, 8'h00, 12'h15F, 8'h01, 1'b1, 2'd1},
    '{16'h4860, 4'h0, 1'b1, 12'h100, 1'b0, 8'hFF, 12'hF60, 8'h00, 1'b0, 2'd0},
    '{16'h4BFF, 4'hF, 1'b0, 12'h000, 1'b1, 8'h41, 12'hFFF, 8'h42, 1'b1, 2'd2},
    '{16'h4A10, 4'h0, 1'b1, 12'hFF8, 1'b0, 8'hFF, 12'h008, 8'h00, 1'b1, 2'd0},
    '{16'h3C00, 4'h0, 1'b1, 12'h0A0, 1'b1, 8'hFF, 12'h0A0, 8'h00, 1'b0, 2'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0;
  logic ins_ready;
  logic [15:0] ins_word = '0;
  logic next_dbl = 1'b0;
  logic ext_en = 1'b0;
  logic [AW-1:0] fsr2 = '0;
  logic w_ld = 1'b0;
  logic [DW-1:0] w_ld_val = '0;
  logic bsr_ld = 1'b0;
  logic [AW-DW-1:0] bsr_ld_val = '0;
  logic [DW-1:0] w_q;
  logic [AW-DW-1:0] bsr_q;
  logic [AW-1:0] mem_addr;
  logic mem_rd;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_we;
  logic [DW-1:0] mem_wdata;
  logic squash;

  always #(CLK_PERIOD/2) clk = ~clk;

  incskip_unit u_incskip_unit (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .next_dbl(next_dbl), .ext_en(ext_en), .fsr2(fsr2),
    .w_ld(w_ld), .w_ld_val(w_ld_val), .bsr_ld(bsr_ld), .bsr_ld_val(bsr_ld_val),
    .w_q(w_q), .bsr_q(bsr_q), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .squash(squash)
  );

  // Memory model: returns the preset byte one clock after a read.
  logic [7:0]  mem_preset = '0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [11:0] rd_addr = '0;
  logic [11:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem_preset;
      rd_addr   <= mem_addr;
      rd_cnt    <= rd_cnt + 1;
    end
    if (mem_we) begin
      wr_addr <= mem_addr;
      wr_data <= mem_wdata;
      wr_cnt  <= wr_cnt + 1;
    end
  end

  int checks = 0;
  int errors = 0;
  int busy, sq, rd_idx, we_idx;
  logic [7:0] exp_w;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic load_regs(input logic [7:0] wv, input logic [3:0] bv);
    @(negedge clk);
    w_ld = 1'b1; w_ld_val = wv; bsr_ld = 1'b1; bsr_ld_val = bv;
    @(negedge clk);
    w_ld = 1'b0; bsr_ld = 1'b0;
  endtask

  task automatic run(input logic [15:0] ins, input logic dbl);
    @(negedge clk);
    ins_valid = 1'b1; ins_word = ins; next_dbl = dbl;
    @(negedge clk);
    ins_valid = 1'b0;
    busy = 0; sq = 0; rd_idx = -1; we_idx = -1;
    while (!ins_ready && busy < 40) begin
      if (squash) sq++;
      if (mem_rd) rd_idx = busy;
      if (mem_we) we_idx = busy;
      busy++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r0, w0;
    repeat (3) @(negedge clk);
    // R9 R10: reset state
    chk("R9 ready after reset", 32'(ins_ready), 32'd1);
    chk("R8 squash after reset", 32'(squash), 32'd0);
    chk("R7 no access after reset", 32'({mem_rd, mem_we}), 32'd0);
    chk("R10 W reset", 32'(w_q), 32'd0);
    chk("R10 bank reset", 32'(bsr_q), 32'd0);
    rst_n = 1'b1;
    exp_w = 8'h00;

    // Vector walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      exp_w = 8'h5A + 8'(i);
      load_regs(exp_w, VEC[i].bank);
      ext_en = VEC[i].ext; fsr2 = VEC[i].base; mem_preset = VEC[i].pre;
      r0 = rd_cnt; w0 = wr_cnt;
      run(VEC[i].ins, VEC[i].dbl);
      chk("R7 one read", 32'(rd_cnt - r0), 32'd1);
      chk("R2/R3/R4 operand address", 32'(rd_addr), 32'(VEC[i].eaddr));
      chk("R7 read in phase 1", 32'(rd_idx), 32'd1);
      if (VEC[i].emem) begin
        chk("R5 one write", 32'(wr_cnt - w0), 32'd1);
        chk("R5 write address", 32'(wr_addr), 32'(VEC[i].eaddr));
        chk("R5 write value", 32'(wr_data), 32'(VEC[i].eval));
        chk("R7 write in phase 3", 32'(we_idx), 32'd3);
        chk("R5 W untouched", 32'(w_q), 32'(exp_w));
      end else begin
        chk("R5 no write", 32'(wr_cnt - w0), 32'd0);
        chk("R5 W result", 32'(w_q), 32'(VEC[i].eval));
      end
      chk("R6 R8 squash count", 32'(sq), 32'(VEC[i].esq));
      chk("R8 busy clocks", 32'(busy), 32'(4 * (1 + VEC[i].esq)));
    end

    // R1: undefined word is dropped
    load_regs(8'h33, 4'h2);
    ext_en = 1'b0; mem_preset = 8'hFF;
    r0 = rd_cnt; w0 = wr_cnt;
    run(16'h2A00, 1'b1);
    chk("R1 undefined busy one clock", 32'(busy), 32'd1);
    chk("R1 undefined no read", 32'(rd_cnt - r0), 32'd0);
    chk("R1 undefined no write", 32'(wr_cnt - w0), 32'd0);
    chk("R1 undefined W unchanged", 32'(w_q), 32'h33);
    chk("R1 undefined no squash", 32'(sq), 32'd0);

    // R9 R10: bank load and held word while busy are ignored
    load_regs(8'h00, 4'h3);
    mem_preset = 8'h05;
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    ins_valid = 1'b1; ins_word = 16'h3F20; next_dbl = 1'b0;
    @(negedge clk);
    ins_word = 16'h3F30; bsr_ld = 1'b1; bsr_ld_val = 4'h9;
    @(negedge clk);
    @(negedge clk);
    ins_valid = 1'b0; bsr_ld = 1'b0;
    while (!ins_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R10 bank load ignored while busy", 32'(bsr_q), 32'h3);
    chk("R10 address used old bank", 32'(rd_addr), 32'h320);
    chk("R9 held word not taken", 32'(rd_cnt - r0), 32'd1);
    chk("R9 single write", 32'(wr_cnt - w0), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule